// File: doc/BRIEF.md
# Indirect Entry Table with Register Window

This block holds a table of wide entries that a host can only reach through a small register window. Each entry is wider than a bus word, so it is split across three 32-bit staging registers. To read an entry, the host writes its index to the table-control register; the block copies that entry into the staging words, and the host then reads them. To write an entry, the host fills the staging words and then writes the index with the commit bit (bit 31) set.

The word order is reversed: the lowest-address staging word carries the top of the entry, and the highest-address word carries bits 31:0. Besides the table, the window has an identification register, a status register that encodes the table depth, and a global control register. The control register holds an enable flag and a clear bit. The clear bit starts a sweep that empties every entry, one per cycle.

The register bus is a single-beat valid/ready interface. It accepts a request every cycle and returns read data one cycle later.

Top module: `lut_window`

## Requirements
- R1: Offset 0x00 reads the minor revision in bits 7:0 and the major revision in bits 15:8, with all other bits zero. The default revision is 1.4.
- R2: Offset 0x04 reads the table size code in bits 4:0, with all other bits zero. The code is 0 for a 64-entry table and DEPTH/1024 otherwise, so the default reads 0.
- R3: Writing offset 0x20 with bit 31 clear latches the index from the low 16 bits and loads that entry into the staging words. Staging word 0x34 holds entry bits 95:64, 0x38 holds bits 63:32 and 0x3C holds bits 31:0. Offset 0x20 reads back the latched index.
- R4: Writing offset 0x20 with bit 31 set stores the three staging words into the entry at the index in the low 16 bits.
- R5: Entry bits at or above ENTRY_W (default 72) are not stored, so they read back as zero after a store and a reload.
- R6: An index at or beyond DEPTH leaves every entry unchanged on a commit, and a latch with such an index loads zeros into all three staging words.
- R7: Writing 1 to control bit 30 sets every entry to zero, so its type field (entry bits 61:60) reads 0. The sweep clears one entry per cycle, and bit 30 reads 1 until the sweep has finished, at most DEPTH cycles later.
- R8: While the sweep runs, host writes to the staging words and commits are ignored.
- R9: Control bit 31 is a read/write enable flag that resets to 0.
- R10: req_ready is always 1. Every read request gets rsp_valid in the next cycle. Unmapped offsets read zero.
- R11: After reset, the staging words, the latched index and all entries are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |

## Verification
A wrong latched index or a wrong word ordering shows up on the very next read of a staging word, as data from the wrong entry or in the wrong slot. Storage faults such as truncation, out-of-range wraparound or a missed commit stay hidden until the host latches the affected index again. The bench therefore always reloads before comparing. A sweep that ends early or late is seen by polling the clear bit. An incomplete sweep shows only as nonzero data when the last entries are reloaded.

// File: rtl/lut_window.sv
module lut_window #(
  parameter int DEPTH     = 64,
  parameter int ENTRY_W   = 72,
  parameter int AW        = 8,
  parameter logic [7:0] VER_MAJOR = 8'h01,
  parameter logic [7:0] VER_MINOR = 8'h04
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  output logic [31:0]   rsp_rdata
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int XW = 16;
  localparam logic [4:0] SIZE_CODE = (DEPTH == 64) ? 5'd0 : 5'(DEPTH / 1024);
  localparam logic [AW-1:0] A_ID   = AW'('h00);
  localparam logic [AW-1:0] A_STAT = AW'('h04);
  localparam logic [AW-1:0] A_CTL  = AW'('h08);
  localparam logic [AW-1:0] A_TAB  = AW'('h20);
  localparam logic [AW-1:0] A_W0   = AW'('h34);
  localparam logic [AW-1:0] A_W1   = AW'('h38);
  localparam logic [AW-1:0] A_W2   = AW'('h3C);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [31:0]   word_q [3];
  logic [XW-1:0] idx_q;
  logic          en_q, busy_q;
  logic [IW-1:0] sweep_q;
  logic [31:0]   rdata_c;

  wire          wr        = req_valid & req_write;
  wire          rd        = req_valid & ~req_write;
  wire          wr_ctl    = wr && (req_addr == A_CTL);
  wire          wr_tab    = wr && (req_addr == A_TAB);
  wire [XW-1:0] idx_new   = req_wdata[XW-1:0];
  wire          in_range  = 32'(idx_new) < DEPTH;
  wire          latch     = wr_tab & ~req_wdata[31];
  wire          commit    = wr_tab & req_wdata[31] & ~busy_q & in_range;
  wire [95:0]   stage_all = {word_q[0], word_q[1], word_q[2]};
  wire [95:0]   rd_entry  = in_range ? 96'(mem[idx_new[IW-1:0]]) : 96'd0;
  wire [AW-1:0] word_addr [3] = '{A_W0, A_W1, A_W2};

  assign req_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (busy_q) begin
      mem[sweep_q] <= '0;
    end else if (commit) begin
      mem[idx_new[IW-1:0]] <= stage_all[ENTRY_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      busy_q  <= 1'b0;
      sweep_q <= '0;
    end else begin
      if (wr_ctl) en_q <= req_wdata[31];
      if (busy_q) begin
        if (sweep_q == IW'(DEPTH - 1)) busy_q <= 1'b0;
        else sweep_q <= sweep_q + 1'b1;
      end else if (wr_ctl && req_wdata[30]) begin
        busy_q  <= 1'b1;
        sweep_q <= '0;
      end
    end
  end

  for (genvar g = 0; g < 3; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) word_q[g] <= '0;
      else if (latch) word_q[g] <= rd_entry[95-32*g -: 32];
      else if (wr && req_addr == word_addr[g] && !busy_q) word_q[g] <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) idx_q <= '0;
    else if (wr_tab) idx_q <= idx_new;
  end

  always_comb begin
    case (req_addr)
      A_ID:    rdata_c = {16'd0, VER_MAJOR, VER_MINOR};
      A_STAT:  rdata_c = {27'd0, SIZE_CODE};
      A_CTL:   rdata_c = {en_q, busy_q, 30'd0};
      A_TAB:   rdata_c = {{(32-XW){1'b0}}, idx_q};
      A_W0:    rdata_c = word_q[0];
      A_W1:    rdata_c = word_q[1];
      A_W2:    rdata_c = word_q[2];
      default: rdata_c = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      rsp_rdata <= rd ? rdata_c : 32'd0;
    end
  end

  p_commit_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> mem[$past(idx_new[IW-1:0])] == $past(stage_all[ENTRY_W-1:0]));
  p_oob_latch_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && !in_range) |=> stage_all == 96'd0);
  p_clear_starts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && req_wdata[30] && !busy_q) |=> busy_q && sweep_q == '0);
  p_sweep_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && sweep_q == IW'(DEPTH - 1)) |=> !busy_q && mem[DEPTH-1] == '0);
  p_busy_word_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wr && (req_addr == A_W0 || req_addr == A_W1 || req_addr == A_W2))
    |=> $stable(stage_all));
endmodule

// File: tb/test_lut_window.sv
module test_lut_window;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int NV = 20;
  // {write, addr[7:0], data}; for reads, data is the expected value
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 8'h34, 32'hAABBCCDD}, {1'b1, 8'h38, 32'h11223344},
    {1'b1, 8'h3C, 32'h55667788}, {1'b1, 8'h20, 32'h80000005},
    {1'b1, 8'h34, 32'h000000EE}, {1'b1, 8'h38, 32'h99990000},
    {1'b1, 8'h3C, 32'h0000FFFF}, {1'b1, 8'h20, 32'h80000009},
    {1'b1, 8'h20, 32'h00000005}, {1'b0, 8'h34, 32'h000000DD},
    {1'b0, 8'h38, 32'h11223344}, {1'b0, 8'h3C, 32'h55667788},
    {1'b0, 8'h20, 32'h00000005}, {1'b1, 8'h20, 32'h00000009},
    {1'b0, 8'h34, 32'h000000EE}, {1'b0, 8'h38, 32'h99990000},
    {1'b0, 8'h3C, 32'h0000FFFF}, {1'b1, 8'h20, 32'h0000003F},
    {1'b0, 8'h3C, 32'h00000000}, {1'b0, 8'h34, 32'h00000000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lut_window #(.DEPTH(DEPTH)) i_lut_window (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    if (!rsp_valid) begin
      n_bad++;
      $display("FAIL R10: rsp_valid got 0 expected 1");
    end
    n_chk++;
    d = rsp_rdata;
    req_valid = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a, d);
    check(tag, d, exp);
  endtask

  initial begin
    logic [31:0] d;
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state R11, identity R1, size R2, enable R9
    check("R10 ready", {31'd0, req_ready}, 32'd1);
    rd_chk("R1 id", 8'h00, 32'h00000104);
    rd_chk("R2 status", 8'h04, 32'h00000000);
    rd_chk("R9 ctl reset", 8'h08, 32'h00000000);
    rd_chk("R11 word0", 8'h34, 32'h0);
    rd_chk("R11 word2", 8'h3C, 32'h0);
    rd_chk("R11 index", 8'h20, 32'h0);
    bus_wr(8'h20, 32'h00000007);
    rd_chk("R11 entry7", 8'h38, 32'h0);
    // vector walk: R3 R4 R5
    for (int k = 0; k < NV; k++) begin
      if (VEC[k][40]) bus_wr(VEC[k][39:32], VEC[k][31:0]);
      else rd_chk($sformatf("R3 R4 R5 vec %0d", k), VEC[k][39:32], VEC[k][31:0]);
    end
    // R10 unmapped
    rd_chk("R10 unmapped", 8'h10, 32'h0);
    // R6 out of range commit and latch
    bus_wr(8'h34, 32'h000000A1);
    bus_wr(8'h38, 32'hA2A2A2A2);
    bus_wr(8'h3C, 32'hA3A3A3A3);
    bus_wr(8'h20, 32'h80000040);
    bus_wr(8'h20, 32'h00000040);
    rd_chk("R6 oob w0", 8'h34, 32'h0);
    rd_chk("R6 oob w2", 8'h3C, 32'h0);
    bus_wr(8'h20, 32'h00000000);
    rd_chk("R6 entry0 untouched", 8'h3C, 32'h0);
    bus_wr(8'h20, 32'h00000005);
    rd_chk("R6 entry5 untouched", 8'h38, 32'h11223344);
    // R7 clear sweep with R8 ignore
    bus_wr(8'h20, 32'h00000009);
    bus_wr(8'h08, 32'hC0000000);
    rd_chk("R7 clear busy", 8'h08, 32'hC0000000);
    bus_wr(8'h3C, 32'h12345678);
    rd_chk("R8 word ignored", 8'h3C, 32'h0000FFFF);
    cyc = 0;
    do begin
      bus_rd(8'h08, d);
      cyc++;
    end while (d[30] && cyc < 2 * DEPTH);
    check("R7 sweep ends", d, 32'h80000000);
    bus_wr(8'h20, 32'h00000009);
    rd_chk("R7 entry9 w1 cleared", 8'h38, 32'h0);
    rd_chk("R7 entry9 w2 cleared", 8'h3C, 32'h0);
    bus_wr(8'h20, 32'h00000005);
    rd_chk("R7 entry5 type cleared", 8'h38, 32'h0);
    bus_wr(8'h08, 32'h00000000);
    rd_chk("R9 enable cleared", 8'h08, 32'h0);
    // R4 after sweep, last entry
    bus_wr(8'h3C, 32'hCAFE0001);
    bus_wr(8'h20, 32'h8000003F);
    bus_wr(8'h20, 32'h0000003F);
    rd_chk("R4 last entry", 8'h3C, 32'hCAFE0001);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule